// File: doc/BRIEF.md
# Hashed Filter Table Engine

This block owns one open-addressed table of packet filters kept in on-chip storage, with a used bit per slot. A controller issues insert, delete, lookup and clear commands over a request/response handshake. Each command carries a filter type, three 32-bit match words, a queue id and a flag that allows an existing entry to be overwritten. The engine turns the match words into a hash key. It walks an open-addressing probe chain, one slot per clock, and reports a two-bit status, the slot index and, for lookups, the stored queue id.

For every filter type the engine records the deepest probe at which an insert succeeded. From that depth it drives a search-limit value for the packet-side matcher, which stops walking a chain once it has gone that far. The limit adds a pipeline margin that is larger for wildcard types than for exact types. The recorded depths return to zero whenever the table becomes empty. A clear command sweeps the whole table one slot per cycle.

The filter type is two bits: bit 0 set means a wildcard type, and bit 1 selects UDP over TCP. A parameter chooses whether the table serves the transmit side, where the queue id is part of the match, or the receive side, where it is not.

Top module: `filt_table_engine`

## Requirements
- R1: A command is taken only while `cmd_ready` is high, and only one command is in progress at a time. Each command yields exactly one single-cycle `resp_valid` pulse. The opcodes are 0 insert, 1 delete, 2 lookup and 3 clear-all. The status codes are 0 ok, 1 busy, 2 not-found and 3 exists.
- R2: The key is the XOR of the three match words and the zero-extended type. The first probe goes to slot hash(key) mod SLOTS, where hash is the 16-bit LFSR fold of x^16+x^3+1. Each later probe adds the odd stride (2*key-1) mod SLOTS to the slot index.
- R3: A slot matches only when it is used, its type equals the request type and all three words are equal. The queue id is compared only in a transmit table, so in a receive table a lookup with a different queue id still hits.
- R4: An insert stops at the first slot that is unused or matching. If it takes an unused slot, it marks the slot used, stores the entry and answers ok with that index.
- R5: An insert that reaches a matching slot with the replace flag clear answers exists and leaves the stored entry unchanged. With the flag set, it overwrites the entry in place, answers ok with the same index and leaves the used count unchanged.
- R6: A lookup stops only at a matching slot, answers ok with its index and stored queue id, and passes over unused slots. A lookup that finds no match answers not-found.
- R7: The probe walk gives up at depth 200. An insert then answers busy, even when the table is full.
- R8: A delete of a matching entry clears its used bit, zeroes the slot and answers ok, after which a lookup of that entry misses. A delete that finds no match answers not-found and changes nothing.
- R9: The depth of a probe counts from 1 at the first slot. A successful insert raises the recorded maximum for its type when its depth is greater. `search_limit` field t (bits t*LW upward) equals that maximum plus 1 for exact types or plus 3 for wildcard types.
- R10: `used_count` rises by one for each insert into an unused slot and falls by one for each entry removed by delete or clear.
- R11: When a delete brings `used_count` to zero, every recorded depth resets to 0 in the same cycle as the response.
- R12: A clear-all visits every slot, one per cycle, and answers ok exactly SLOTS cycles after acceptance. At that point the table is empty, the count is zero and all depths are reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_op | input | 2 | Opcode |
| cmd_type | input | 2 | Filter type (bit 0 wildcard, bit 1 UDP) |
| cmd_word0 | input | 32 | Match word 0 |
| cmd_word1 | input | 32 | Match word 1 |
| cmd_word2 | input | 32 | Match word 2 |
| cmd_qid | input | QID_W | Queue id |
| cmd_replace | input | 1 | Allow overwrite of a matching entry |
| resp_valid | output | 1 | Response pulse |
| resp_status | output | 2 | Status code |
| resp_index | output | IW | Slot index of a hit |
| resp_qid | output | QID_W | Stored queue id (lookup hit) |
| used_count | output | IW+1 | Occupied slots |
| search_limit | output | 4*LW | Per-type search limits |

## Verification
A corrupted used bit or stored entry appears at the very next command that touches that chain. A probe that should stop on a match either runs on to not-found after 200 cycles or lands on the wrong index. A stale depth register appears on `search_limit` in the cycle after the faulty update. The bench builds collision chains by permuting the match words, which keeps the key and so the chain the same. It can then predict the second and third slot from the stride alone, which exposes any error in probe stepping or in the match test. An error in the count or in reset-on-empty shows on `used_count` and `search_limit` in the same cycle as the response that should have changed them.

// File: rtl/filt_pkg.sv
// Shared types and key/hash helpers for the hashed filter table engine.
// Assumes three 32-bit match words and four filter types per table.
package filt_pkg;
    localparam int QID_W  = 8;
    localparam int NTYPES = 4;
    localparam int NWORDS = 3;

    typedef enum logic [1:0] {
        OP_INSERT = 2'd0,
        OP_DELETE = 2'd1,
        OP_LOOKUP = 2'd2,
        OP_CLEAR  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_OK       = 2'd0,
        ST_BUSY     = 2'd1,
        ST_NOTFOUND = 2'd2,
        ST_EXISTS   = 2'd3
    } status_e;

    typedef struct packed {
        logic [1:0]                   ftype;
        logic [NWORDS-1:0][31:0]      words;
        logic [QID_W-1:0]             qid;
    } slot_t;

    // Fold type and match words into the 32-bit hash key.
    function automatic logic [31:0] fold_key(input logic [1:0] ftype,
                                             input logic [NWORDS-1:0][31:0] words);
        logic [31:0] k;
        k = {30'd0, ftype};
        for (int i = 0; i < NWORDS; i++) k = k ^ words[i];
        return k;
    endfunction

    // Sixteen-bit LFSR fold of the key (polynomial x^16 + x^3 + 1).
    function automatic logic [15:0] lfsr_fold(input logic [31:0] k);
        logic [15:0] t;
        t = 16'h1fff ^ k[31:16];
        t = t ^ (t >> 3) ^ (t >> 6);
        t = t ^ (t >> 9);
        t = t ^ (t << 13) ^ k[15:0];
        t = t ^ (t >> 3) ^ (t >> 6);
        t = t ^ (t >> 9);
        return t;
    endfunction
endpackage

// File: rtl/filt_probe_gen.sv
// Probe-chain origin: derives the first slot and the odd stride from a request.
// Assumes SLOTS is a power of two no larger than 65536.
module filt_probe_gen
    import filt_pkg::*;
#(
    parameter int SLOTS = 64,
    localparam int IW = $clog2(SLOTS)
) (
    input  logic [1:0]              ftype_i,
    input  logic [NWORDS-1:0][31:0] words_i,
    output logic [IW-1:0]           start_o,
    output logic [IW-1:0]           stride_o
);
    logic [31:0] key;

    // Key, hashed start slot and odd stride, all combinational.
    always_comb begin
        key      = fold_key(ftype_i, words_i);
        start_o  = IW'(lfsr_fold(key));
        stride_o = IW'((key << 1) - 32'd1);
    end
endmodule

// File: rtl/filt_slot_store.sv
// Slot storage: entry array with asynchronous read plus a resettable used bitmap.
// Assumes a single write port; a cleared slot is written back as all zeros.
module filt_slot_store
    import filt_pkg::*;
#(
    parameter int SLOTS = 64,
    localparam int IW = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_used,
    output slot_t         rd_entry,
    input  logic          wr_en,
    input  logic          wr_set,
    input  logic [IW-1:0] wr_idx,
    input  slot_t         wr_entry
);
    slot_t             mem_q [SLOTS];
    logic [SLOTS-1:0]  used_q;

    // Entry write: store on set, zero on clear.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_set ? wr_entry : '0;
    end

    // Used bitmap update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     used_q <= '0;
        else if (wr_en) used_q[wr_idx] <= wr_set;
    end

    // Read port for the slot under probe.
    always_comb begin
        rd_used  = used_q[rd_idx];
        rd_entry = mem_q[rd_idx];
    end
endmodule

// File: rtl/filt_depth_track.sv
// Per-type deepest successful probe and derived search limits.
// Assumes type bit 0 marks a wildcard type; clear has priority over update.
module filt_depth_track
    import filt_pkg::*;
#(
    parameter int MAX_PROBES  = 200,
    parameter int FUDGE_EXACT = 1,
    parameter int FUDGE_WILD  = 3,
    localparam int DW = $clog2(MAX_PROBES + 1),
    localparam int LW = $clog2(MAX_PROBES + FUDGE_WILD + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_i,
    input  logic [1:0]         upd_type_i,
    input  logic [DW-1:0]      upd_depth_i,
    input  logic               clr_i,
    output logic [NTYPES*LW-1:0] limit_o
);
    logic [DW-1:0] max_q [NTYPES];

    // Raise a type's maximum on a deeper insert; drop all on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            for (int t = 0; t < NTYPES; t++) max_q[t] <= '0;
        end else if (upd_i && (upd_depth_i > max_q[upd_type_i])) begin
            max_q[upd_type_i] <= upd_depth_i;
        end
    end

    for (genvar g = 0; g < NTYPES; g++) begin : g_type
        localparam int FUDGE = (g % 2 == 1) ? FUDGE_WILD : FUDGE_EXACT;

        // Limit field for this type.
        assign limit_o[g*LW +: LW] = LW'(max_q[g]) + LW'(FUDGE);

        assert_depth_monotone_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i && $past(rst_n)) |=> (max_q[g] >= $past(max_q[g])));

        assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
            max_q[g] <= DW'(MAX_PROBES));
    end
endmodule

// File: rtl/filt_table_engine.sv
// Hashed filter table engine: runs insert/delete/lookup probe walks and clear sweeps
// over one open-addressed table, one slot per cycle, tracking per-type probe depth.
// Assumes SLOTS is a power of two and the requester waits for each response.
module filt_table_engine
    import filt_pkg::*;
#(
    parameter int SLOTS       = 64,
    parameter int MAX_PROBES  = 200,
    parameter int IS_TX       = 0,
    parameter int FUDGE_EXACT = 1,
    parameter int FUDGE_WILD  = 3,
    localparam int IW = $clog2(SLOTS),
    localparam int DW = $clog2(MAX_PROBES + 1),
    localparam int LW = $clog2(MAX_PROBES + FUDGE_WILD + 1),
    localparam int CW = IW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [1:0]           cmd_op,
    input  logic [1:0]           cmd_type,
    input  logic [31:0]          cmd_word0,
    input  logic [31:0]          cmd_word1,
    input  logic [31:0]          cmd_word2,
    input  logic [QID_W-1:0]     cmd_qid,
    input  logic                 cmd_replace,
    output logic                 resp_valid,
    output logic [1:0]           resp_status,
    output logic [IW-1:0]        resp_index,
    output logic [QID_W-1:0]     resp_qid,
    output logic [CW-1:0]        used_count,
    output logic [NTYPES*LW-1:0] search_limit
);
    typedef enum logic [1:0] {S_IDLE, S_PROBE, S_SWEEP} state_e;

    state_e           state_q;
    op_e              op_q;
    slot_t            cur_q;
    logic             rep_q;
    logic [IW-1:0]    idx_q, stride_q;
    logic [DW-1:0]    depth_q;
    logic [CW-1:0]    count_q;

    logic [NWORDS-1:0][31:0] cmd_words;
    logic [IW-1:0]    start_c, stride_c;
    logic             accept;

    logic             rd_used;
    slot_t            rd_entry;
    logic             qid_ok, slot_match, found, exhausted, is_ins;
    logic             wr_en, wr_set, upd, dclr, cnt_inc, cnt_dec, finish;
    status_e          fin_status;
    logic [IW-1:0]    fin_index;
    logic [QID_W-1:0] fin_qid;

    assign cmd_words = {cmd_word2, cmd_word1, cmd_word0};
    assign cmd_ready = (state_q == S_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign used_count = count_q;

    filt_probe_gen #(.SLOTS(SLOTS)) u_probe (
        .ftype_i  (cmd_type),
        .words_i  (cmd_words),
        .start_o  (start_c),
        .stride_o (stride_c)
    );

    filt_slot_store #(.SLOTS(SLOTS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (idx_q),
        .rd_used  (rd_used),
        .rd_entry (rd_entry),
        .wr_en    (wr_en),
        .wr_set   (wr_set),
        .wr_idx   (idx_q),
        .wr_entry (cur_q)
    );

    filt_depth_track #(
        .MAX_PROBES  (MAX_PROBES),
        .FUDGE_EXACT (FUDGE_EXACT),
        .FUDGE_WILD  (FUDGE_WILD)
    ) u_depth (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_i       (upd),
        .upd_type_i  (cur_q.ftype),
        .upd_depth_i (depth_q),
        .clr_i       (dclr),
        .limit_o     (search_limit)
    );

    // Queue id takes part in the match only for a transmit table.
    if (IS_TX != 0) begin : g_txq
        assign qid_ok = (rd_entry.qid == cur_q.qid);
    end else begin : g_rxq
        assign qid_ok = 1'b1;
    end

    // Per-cycle decision for the slot under the probe pointer.
    always_comb begin
        is_ins     = (op_q == OP_INSERT);
        slot_match = rd_used && (rd_entry.ftype == cur_q.ftype) &&
                     (rd_entry.words == cur_q.words) && qid_ok;
        found      = is_ins ? (!rd_used || slot_match) : slot_match;
        exhausted  = (depth_q == DW'(MAX_PROBES));
        wr_en = 1'b0; wr_set = 1'b0; upd = 1'b0; dclr = 1'b0;
        cnt_inc = 1'b0; cnt_dec = 1'b0; finish = 1'b0;
        fin_status = ST_OK; fin_index = '0; fin_qid = '0;
        case (state_q)
            S_PROBE: begin
                if (found) begin
                    finish    = 1'b1;
                    fin_index = idx_q;
                    case (op_q)
                        OP_INSERT: begin
                            if (!rd_used) begin
                                wr_en = 1'b1; wr_set = 1'b1; upd = 1'b1; cnt_inc = 1'b1;
                            end else if (rep_q) begin
                                wr_en = 1'b1; wr_set = 1'b1; upd = 1'b1;
                            end else begin
                                fin_status = ST_EXISTS;
                            end
                        end
                        OP_DELETE: begin
                            wr_en   = 1'b1;
                            cnt_dec = 1'b1;
                            dclr    = (count_q == CW'(1));
                        end
                        default: fin_qid = rd_entry.qid;
                    endcase
                end else if (exhausted) begin
                    finish     = 1'b1;
                    fin_status = is_ins ? ST_BUSY : ST_NOTFOUND;
                end
            end
            S_SWEEP: begin
                wr_en   = 1'b1;
                cnt_dec = rd_used;
                if (idx_q == IW'(SLOTS - 1)) begin
                    finish = 1'b1;
                    dclr   = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // Command capture, probe stepping and state sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            op_q     <= OP_LOOKUP;
            cur_q    <= '0;
            rep_q    <= 1'b0;
            idx_q    <= '0;
            stride_q <= '0;
            depth_q  <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (accept) begin
                    op_q     <= op_e'(cmd_op);
                    cur_q    <= '{ftype: cmd_type, words: cmd_words, qid: cmd_qid};
                    rep_q    <= cmd_replace;
                    stride_q <= stride_c;
                    depth_q  <= DW'(1);
                    if (op_e'(cmd_op) == OP_CLEAR) begin
                        state_q <= S_SWEEP;
                        idx_q   <= '0;
                    end else begin
                        state_q <= S_PROBE;
                        idx_q   <= start_c;
                    end
                end
                S_PROBE: begin
                    if (finish) state_q <= S_IDLE;
                    else begin
                        idx_q   <= idx_q + stride_q;
                        depth_q <= depth_q + DW'(1);
                    end
                end
                S_SWEEP: begin
                    if (finish) state_q <= S_IDLE;
                    else        idx_q   <= idx_q + IW'(1);
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_q + CW'(cnt_inc) - CW'(cnt_dec);
    end

    // Registered single-cycle response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_status <= ST_OK;
            resp_index  <= '0;
            resp_qid    <= '0;
        end else begin
            resp_valid <= finish;
            if (finish) begin
                resp_status <= fin_status;
                resp_index  <= fin_index;
                resp_qid    <= fin_qid;
            end
        end
    end

    assert_resp_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_one_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    assert_probe_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PROBE) |-> ((depth_q != '0) && (depth_q <= DW'(MAX_PROBES))));

    assert_busy_only_insert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_status == ST_BUSY) |-> (op_q == OP_INSERT));

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        used_count <= CW'(SLOTS));

    assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((used_count == $past(used_count)) ||
                          (used_count == $past(used_count) + CW'(1)) ||
                          (used_count + CW'(1) == $past(used_count))));
endmodule

// File: tb/tb_filt_table_engine.sv
`timescale 1ns/1ps
module tb_filt_table_engine;
    import filt_pkg::*;

    localparam int SLOTS = 64;
    localparam int IW    = $clog2(SLOTS);
    localparam int LW    = $clog2(200 + 3 + 1);
    localparam int CW    = IW + 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_ready, cmd_replace = 1'b0;
    logic [1:0] cmd_op = '0, cmd_type = '0;
    logic [31:0] cmd_word0 = '0, cmd_word1 = '0, cmd_word2 = '0;
    logic [QID_W-1:0] cmd_qid = '0;
    logic resp_valid;
    logic [1:0] resp_status;
    logic [IW-1:0] resp_index;
    logic [QID_W-1:0] resp_qid;
    logic [CW-1:0] used_count;
    logic [NTYPES*LW-1:0] search_limit;

    filt_table_engine dut (.*);

    always #4 clk = ~clk;

    typedef struct {
        logic [1:0]       st;
        bit               ci;
        logic [IW-1:0]    idx;
        bit               cq;
        logic [QID_W-1:0] qid;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t mon_e;
    int n_cmp = 0, n_fail = 0, resp_seen = 0;
    int cyc = 0, acc_cyc = 0, resp_cyc = 0;
    logic [IW-1:0] last_idx;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] lim(input int t);
        return search_limit[t*LW +: LW];
    endfunction

    // Monitor: pop the scoreboard on each response and compare.
    always @(negedge clk) begin
        if (resp_valid) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected response", 1, 0);
            end else begin
                mon_e = exp_q.pop_front();
                check({mon_e.tag, " status"}, 32'(resp_status), 32'(mon_e.st));
                if (mon_e.ci) check({mon_e.tag, " index"}, 32'(resp_index), 32'(mon_e.idx));
                if (mon_e.cq) check({mon_e.tag, " qid"}, 32'(resp_qid), 32'(mon_e.qid));
            end
            last_idx = resp_index;
            resp_cyc = cyc;
            resp_seen++;
        end
    end

    // Driver: push the expectation, issue the command, wait for its response.
    task automatic issue(input logic [1:0] op, input logic [1:0] ty,
                         input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                         input logic [QID_W-1:0] q, input bit rep,
                         input logic [1:0] est, input bit ci, input logic [IW-1:0] ei,
                         input bit cq, input logic [QID_W-1:0] eq, input string tag);
        exp_t e;
        int n0;
        e.st = est; e.ci = ci; e.idx = ei; e.cq = cq; e.qid = eq; e.tag = tag;
        exp_q.push_back(e);
        n0 = resp_seen;
        @(negedge clk);
        cmd_op = op; cmd_type = ty; cmd_word0 = a; cmd_word1 = b; cmd_word2 = c;
        cmd_qid = q; cmd_replace = rep; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        acc_cyc = cyc;
        wait (resp_seen != n0);
    endtask

    function automatic logic [IW-1:0] stride_of(input logic [31:0] k);
        return IW'((k << 1) - 32'd1);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        logic [IW-1:0] ia, ib, ic;
        logic [IW-1:0] st;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check("R1 ready after reset", 32'(cmd_ready), 1);
        check("R1 no response after reset", 32'(resp_valid), 0);
        check("R10 count after reset", 32'(used_count), 0);
        for (int t = 0; t < NTYPES; t++) check("R9 reset limit", 32'(lim(t)), (t % 2) ? 3 : 1);

        // Wildcard insert in empty table, then delete to empty
        issue(2'd0, 2'd1, 1, 2, 3, 8'd1, 0, 2'd0, 0, '0, 0, '0, "R4 wildcard insert");
        check("R9 wildcard limit depth1", 32'(lim(1)), 4);
        check("R9 exact limit untouched", 32'(lim(0)), 1);
        check("R10 count 1", 32'(used_count), 1);
        issue(2'd1, 2'd1, 1, 2, 3, 8'd1, 0, 2'd0, 0, '0, 0, '0, "R8 delete wildcard");
        check("R11 limit reset on empty", 32'(lim(1)), 3);
        check("R10 count 0", 32'(used_count), 0);

        // Collision chain: permuted words share one key (0 for type 0)
        st = stride_of(32'd0);
        issue(2'd0, 2'd0, 1, 2, 3, 8'd5, 0, 2'd0, 0, '0, 0, '0, "R4 insert A");
        ia = last_idx;
        check("R9 limit after depth1", 32'(lim(0)), 2);
        ib = ia + st;
        issue(2'd0, 2'd0, 2, 1, 3, 8'd6, 0, 2'd0, 1, ib, 0, '0, "R2 insert B second probe");
        check("R9 limit after depth2", 32'(lim(0)), 3);
        ic = ib + st;
        issue(2'd0, 2'd0, 3, 1, 2, 8'd7, 0, 2'd0, 1, ic, 0, '0, "R2 insert C third probe");
        check("R9 limit after depth3", 32'(lim(0)), 4);
        check("R10 count 3", 32'(used_count), 3);

        // Replace rules
        issue(2'd0, 2'd0, 1, 2, 3, 8'd8, 0, 2'd3, 1, ia, 0, '0, "R5 insert existing no replace");
        issue(2'd2, 2'd0, 1, 2, 3, 8'd0, 0, 2'd0, 1, ia, 1, 8'd5, "R5 entry unchanged after exists");
        issue(2'd0, 2'd0, 1, 2, 3, 8'd9, 1, 2'd0, 1, ia, 0, '0, "R5 replace in place");
        check("R5 count unchanged on replace", 32'(used_count), 3);
        issue(2'd2, 2'd0, 1, 2, 3, 8'd0, 0, 2'd0, 1, ia, 1, 8'd9, "R3 rx lookup ignores qid, R5 new qid");
        issue(2'd2, 2'd1, 1, 2, 3, 8'd0, 0, 2'd2, 0, '0, 0, '0, "R3 type mismatch misses");
        issue(2'd2, 2'd0, 7, 7, 7, 8'd0, 0, 2'd2, 0, '0, 0, '0, "R6 absent lookup");

        // Delete in middle of chain; lookup must skip the freed slot
        issue(2'd1, 2'd0, 2, 1, 3, 8'd0, 0, 2'd0, 1, ib, 0, '0, "R8 delete B");
        check("R10 count after delete", 32'(used_count), 2);
        issue(2'd2, 2'd0, 2, 1, 3, 8'd0, 0, 2'd2, 0, '0, 0, '0, "R8 deleted entry misses");
        issue(2'd2, 2'd0, 3, 1, 2, 8'd0, 0, 2'd0, 1, ic, 1, 8'd7, "R6 lookup passes unused slot");
        issue(2'd1, 2'd0, 2, 1, 3, 8'd0, 0, 2'd2, 0, '0, 0, '0, "R8 delete absent");
        check("R8 count unchanged on miss", 32'(used_count), 2);
        issue(2'd1, 2'd0, 1, 2, 3, 8'd0, 0, 2'd0, 1, ia, 0, '0, "R8 delete A");
        check("R11 limit kept while nonempty", 32'(lim(0)), 4);
        issue(2'd1, 2'd0, 3, 1, 2, 8'd0, 0, 2'd0, 1, ic, 0, '0, "R8 delete C");
        check("R11 limit reset when empty", 32'(lim(0)), 1);
        check("R10 count empty", 32'(used_count), 0);

        // Fill the table, then overflow
        for (int i = 0; i < SLOTS; i++)
            issue(2'd0, 2'd2, 32'(100 + i), 0, 0, 8'(i), 0, 2'd0, 0, '0, 0, '0, "R4 fill");
        check("R10 count full", 32'(used_count), SLOTS);
        issue(2'd0, 2'd2, 32'd999, 0, 0, 8'd0, 0, 2'd1, 0, '0, 0, '0, "R7 insert into full table");
        check("R7 count unchanged on busy", 32'(used_count), SLOTS);
        issue(2'd2, 2'd2, 32'd999, 0, 0, 8'd0, 0, 2'd2, 0, '0, 0, '0, "R6 lookup in full table");
        issue(2'd2, 2'd2, 32'd130, 0, 0, 8'd0, 0, 2'd0, 0, '0, 1, 8'd30, "R6 lookup hit in full table");

        // Clear-all
        issue(2'd3, 2'd0, 0, 0, 0, 8'd0, 0, 2'd0, 0, '0, 0, '0, "R12 clear all");
        check("R12 sweep length", 32'(resp_cyc - acc_cyc), SLOTS);
        check("R12 count after clear", 32'(used_count), 0);
        for (int t = 0; t < NTYPES; t++) check("R12 limit after clear", 32'(lim(t)), (t % 2) ? 3 : 1);
        issue(2'd2, 2'd2, 32'd100, 0, 0, 8'd0, 0, 2'd2, 0, '0, 0, '0, "R12 cleared entry misses");
        issue(2'd0, 2'd0, 1, 2, 3, 8'd4, 0, 2'd0, 0, '0, 0, '0, "R4 insert after clear");
        check("R10 count after reinsert", 32'(used_count), 1);
        check("R9 limit after reinsert", 32'(lim(0)), 2);

        @(negedge clk);
        check("R1 single pulse", 32'(resp_valid), 0);
        check("R1 scoreboard drained", 32'(exp_q.size()), 0);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end
endmodule